// File: doc/BRIEF.md
# Capacity Usage Monitor Unit

This unit keeps one occupancy counter for each monitoring ID. Software controls it through a 64-bit control word, and it reports counts through a 64-bit snapshot word. A write to the control word starts one of two operations. The first sets which event a counter tracks, plus an optional access-type filter. The second copies a counter into the snapshot word. Each operation runs for a fixed number of cycles. While it runs, a busy flag is set. When it finishes, a status code is published.

Event traffic arrives as single-cycle pulses. Each pulse carries a monitoring ID, a resource-control ID, an access type and an allocate/deallocate flag. The unit turns each pulse into a counter index. It uses the monitoring ID directly, or, in prefixed mode, the resource-control ID with the low monitoring-ID bits below it. A counter that tracks occupancy rises on allocate pulses and falls on deallocate pulses, and it never drops below zero.

The event input has no ready signal. The unit takes every pulse in the cycle it is presented and never applies back-pressure. Control and status pins are plain levels.

Top module: `cap_usage_monitor`

## Requirements
- R1: After reset, `ctl_rdata` and `snap_rdata` read all zeros, and every counter is unconfigured.
- R2: The control word reads back these fields:
  - OP in bits 4:0, AT in 7:5, MCID in 19:8, EVT_ID in 27:20 and ATV in bit 28, each holding the last accepted write.
  - STATUS in bits 38:32 and BUSY in bit 39.
  - Bits 31:29 and 63:40 read zero, whatever was written to them.
- R3: A control write while BUSY is 0 sets BUSY in the next cycle and clears STATUS to 0. BUSY stays 1 for exactly OP_LAT cycles (default 2). STATUS receives the result on the edge where BUSY falls, and otherwise changes only when a write is accepted.
- R4: A control write while BUSY is 1 has no effect. The data written into bits 39:32 never reaches BUSY or STATUS.
- R5: Status codes are 1 success, 2 OP not in {1,2}, 3 MCID >= NUM_CTR, 4 OP=1 with EVT_ID > 1, and 5 OP=1 with ATV=1 and AT >= NUM_AT. When several apply, the lowest code wins.
- R6: OP=1 with EVT_ID=1 clears the selected counter to 0 and starts counting. OP=1 with EVT_ID=0 stops the counter and keeps its value.
- R7: A counting counter adds 1 on an allocate pulse (`ev_dealloc`=0) and subtracts 1 on a deallocate pulse, when the pulse's index matches the counter.
- R8: With ATV=0 pulses of every access type count. With ATV=1 only pulses whose `ev_at` equals the configured AT count.
- R9: A deallocate pulse on a counter at 0 leaves it at 0.
- R10: A successful OP=2 loads `snap_rdata` with the counter value, zero-extended, in bits 62:0. Bit 63 is set when the counter is not counting. The snapshot changes at no other time.
- R11: The pulse index is MCID when PFX_EN=0. When PFX_EN=1 it is (RCID << PFX_BITS) | MCID[PFX_BITS-1:0]. Pulses whose index is >= NUM_CTR are dropped.
- R12: An operation that ends with a status other than 1 changes no counter, no configuration and no snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control-word write strobe |
| reg_wdata | input | 64 | Control-word write data |
| ctl_rdata | output | 64 | Control-word read value |
| snap_rdata | output | 64 | Snapshot-word read value |
| ev_valid | input | 1 | Event pulse present |
| ev_dealloc | input | 1 | 1 = deallocate, 0 = allocate |
| ev_mcid | input | 12 | Monitoring ID of the event |
| ev_rcid | input | RCID_W | Resource-control ID of the event |
| ev_at | input | 3 | Access type of the event |

## Verification
The assertions check the handshake on every cycle:
- BUSY rises after an accepted write and lasts exactly OP_LAT cycles.
- STATUS holds still while idle.
- Writes made during BUSY leave the stored fields alone.
- Completed status codes stay in the defined range.
- The snapshot moves only when an operation completes.

Counter arithmetic needs the bench's scenarios. These scenarios include:
- access-type filtering;
- the zero floor;
- clear-on-configure and hold-on-stop;
- error priority and the absence of side effects on failure;
- prefixed-index formation.

The bench compares each completed operation against an independent model of the counters.

// File: rtl/cum_pkg.sv
package cum_pkg;
  localparam logic [4:0] OPC_CFG_EVT = 5'd1;
  localparam logic [4:0] OPC_SNAP    = 5'd2;

  localparam logic [6:0] ST_OK      = 7'd1;
  localparam logic [6:0] ST_BAD_OP  = 7'd2;
  localparam logic [6:0] ST_BAD_ID  = 7'd3;
  localparam logic [6:0] ST_BAD_EVT = 7'd4;
  localparam logic [6:0] ST_BAD_AT  = 7'd5;

  localparam logic [7:0] EVC_OCCUPANCY = 8'd1;

  localparam int MCID_W = 12;
  localparam int AT_W   = 3;

  localparam int STATUS_LSB = 32;
  localparam int BUSY_BIT   = 39;
  localparam logic [63:0] FIELD_MASK = 64'h0000_0000_1FFF_FFFF;

  // Packed order matches the control-word layout, bit 28 down to bit 0.
  typedef struct packed {
    logic              atv;
    logic [7:0]        evt;
    logic [MCID_W-1:0] mcid;
    logic [AT_W-1:0]   at;
    logic [4:0]        op;
  } ctl_req_t;
endpackage

// File: rtl/cum_index.sv
module cum_index
  import cum_pkg::*;
#(
  parameter int NUM_CTR  = 16,
  parameter int RCID_W   = 12,
  parameter int PFX_EN   = 0,
  parameter int PFX_BITS = 0,
  parameter int IDX_W    = $clog2(NUM_CTR)
) (
  input  logic [MCID_W-1:0] mcid,
  input  logic [RCID_W-1:0] rcid,
  output logic [IDX_W-1:0]  idx,
  output logic              idx_ok
);
  localparam int EW = RCID_W + MCID_W;
  localparam logic [EW-1:0] LOW_MASK = EW'((64'd1 << PFX_BITS) - 64'd1);

  logic [EW-1:0] eff;

  always_comb begin
    if (PFX_EN != 0) eff = (EW'(rcid) << PFX_BITS) | (EW'(mcid) & LOW_MASK);
    else             eff = EW'(mcid);
  end

  assign idx_ok = eff < EW'(NUM_CTR);
  assign idx    = eff[IDX_W-1:0];
endmodule

// File: rtl/cum_seq.sv
module cum_seq
  import cum_pkg::*;
#(
  parameter int NUM_CTR = 16,
  parameter int NUM_AT  = 4,
  parameter int OP_LAT  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [63:0] wdata,
  output logic        busy,
  output logic [6:0]  status,
  output logic [63:0] fields,
  output ctl_req_t    req,
  output logic        done_ok
);
  localparam int LW = (OP_LAT < 2) ? 1 : $clog2(OP_LAT + 1);

  logic [LW-1:0] lat_q;
  logic [6:0]    code;
  logic          last;

  assign req  = ctl_req_t'(fields[28:0]);
  assign last = busy && (lat_q == LW'(OP_LAT - 1));

  always_comb begin
    if (req.op != OPC_CFG_EVT && req.op != OPC_SNAP)                  code = ST_BAD_OP;
    else if (32'(req.mcid) >= NUM_CTR)                                code = ST_BAD_ID;
    else if (req.op == OPC_CFG_EVT && req.evt > EVC_OCCUPANCY)        code = ST_BAD_EVT;
    else if (req.op == OPC_CFG_EVT && req.atv && 32'(req.at) >= NUM_AT) code = ST_BAD_AT;
    else                                                              code = ST_OK;
  end

  assign done_ok = last && (code == ST_OK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields <= '0;
      busy   <= 1'b0;
      status <= '0;
      lat_q  <= '0;
    end else if (wr && !busy) begin
      fields <= wdata & FIELD_MASK;
      busy   <= 1'b1;
      status <= '0;
      lat_q  <= '0;
    end else if (last) begin
      busy   <= 1'b0;
      status <= code;
    end else if (busy) begin
      lat_q  <= lat_q + 1'b1;
    end
  end
endmodule

// File: rtl/cum_ctr_bank.sv
module cum_ctr_bank
  import cum_pkg::*;
#(
  parameter int NUM_CTR = 16,
  parameter int CTR_W   = 16,
  parameter int IDX_W   = $clog2(NUM_CTR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_apply,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_start,
  input  logic             cfg_atv,
  input  logic [AT_W-1:0]  cfg_at,
  input  logic             ev_valid,
  input  logic             ev_dealloc,
  input  logic             ev_ok,
  input  logic [IDX_W-1:0] ev_idx,
  input  logic [AT_W-1:0]  ev_at,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_ctr,
  output logic             rd_inv
);
  localparam logic [CTR_W-1:0] CTR_MAX = '1;

  logic [CTR_W-1:0] ctr_arr [NUM_CTR];
  logic             en_arr  [NUM_CTR];

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic [CTR_W-1:0] ctr_q;
    logic             en_q, atv_q;
    logic [AT_W-1:0]  at_q;
    logic             sel_cfg, hit;

    assign sel_cfg = cfg_apply && (cfg_idx == IDX_W'(i));
    assign hit = ev_valid && ev_ok && (ev_idx == IDX_W'(i)) && en_q &&
                 (!atv_q || (ev_at == at_q));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctr_q <= '0;
        en_q  <= 1'b0;
        atv_q <= 1'b0;
        at_q  <= '0;
      end else if (sel_cfg) begin
        en_q <= cfg_start;
        if (cfg_start) begin
          ctr_q <= '0;
          atv_q <= cfg_atv;
          at_q  <= cfg_at;
        end
      end else if (hit) begin
        if (ev_dealloc) begin
          if (ctr_q != '0) ctr_q <= ctr_q - 1'b1;
        end else if (ctr_q != CTR_MAX) begin
          ctr_q <= ctr_q + 1'b1;
        end
      end
    end

    assign ctr_arr[i] = ctr_q;
    assign en_arr[i]  = en_q;
  end

  assign rd_ctr = ctr_arr[rd_idx];
  assign rd_inv = !en_arr[rd_idx];
endmodule

// File: rtl/cap_usage_monitor.sv
module cap_usage_monitor
  import cum_pkg::*;
#(
  parameter int NUM_CTR  = 16,
  parameter int CTR_W    = 16,
  parameter int NUM_AT   = 4,
  parameter int RCID_W   = 12,
  parameter int PFX_EN   = 0,
  parameter int PFX_BITS = 0,
  parameter int OP_LAT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       ctl_rdata,
  output logic [63:0]       snap_rdata,
  input  logic              ev_valid,
  input  logic              ev_dealloc,
  input  logic [11:0]       ev_mcid,
  input  logic [RCID_W-1:0] ev_rcid,
  input  logic [2:0]        ev_at
);
  localparam int IDX_W = $clog2(NUM_CTR);

  logic             busy, done_ok;
  logic [6:0]       status;
  logic [63:0]      fields;
  ctl_req_t         req;
  logic [IDX_W-1:0] ev_idx, op_idx;
  logic             ev_ok;
  logic [CTR_W-1:0] rd_ctr;
  logic             rd_inv;
  logic [63:0]      snap_q;

  cum_seq #(.NUM_CTR(NUM_CTR), .NUM_AT(NUM_AT), .OP_LAT(OP_LAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
    .busy(busy), .status(status), .fields(fields), .req(req), .done_ok(done_ok)
  );

  cum_index #(.NUM_CTR(NUM_CTR), .RCID_W(RCID_W), .PFX_EN(PFX_EN),
              .PFX_BITS(PFX_BITS), .IDX_W(IDX_W)) u_idx (
    .mcid(ev_mcid), .rcid(ev_rcid), .idx(ev_idx), .idx_ok(ev_ok)
  );

  assign op_idx = req.mcid[IDX_W-1:0];

  cum_ctr_bank #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .cfg_apply(done_ok && req.op == OPC_CFG_EVT), .cfg_idx(op_idx),
    .cfg_start(req.evt == EVC_OCCUPANCY), .cfg_atv(req.atv), .cfg_at(req.at),
    .ev_valid(ev_valid), .ev_dealloc(ev_dealloc), .ev_ok(ev_ok),
    .ev_idx(ev_idx), .ev_at(ev_at),
    .rd_idx(op_idx), .rd_ctr(rd_ctr), .rd_inv(rd_inv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              snap_q <= '0;
    else if (done_ok && req.op == OPC_SNAP) snap_q <= {rd_inv, 63'(rd_ctr)};
  end

  assign snap_rdata = snap_q;

  always_comb begin
    ctl_rdata = fields & FIELD_MASK;
    ctl_rdata[STATUS_LSB +: 7] = status;
    ctl_rdata[BUSY_BIT]        = busy;
  end
endmodule

// File: rtl/cum_checker.sv
module cum_checker #(
  parameter int OP_LAT = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr,
  input logic        busy,
  input logic [6:0]  status,
  input logic [28:0] fields,
  input logic [63:0] snap
);
  logic [15:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  AST_BUSY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !busy) |=> busy); // R3
  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (32'(busy_len) < OP_LAT)); // R3
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (32'(busy_len) == OP_LAT)); // R3
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr) |=> $stable(status)); // R3
  AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr) |=> $stable(fields)); // R4
  AST_STATUS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (status <= 7'd5)); // R5
  AST_SNAP_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(snap) |-> $fell(busy)); // R10
endmodule

bind cap_usage_monitor cum_checker #(.OP_LAT(OP_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr(reg_wr), .busy(ctl_rdata[39]),
  .status(ctl_rdata[38:32]), .fields(ctl_rdata[28:0]), .snap(snap_rdata)
);

// File: tb/cap_usage_monitor_tb_top.sv
`timescale 1ns/1ps
module cap_usage_monitor_tb_top;
  localparam int NC = 16;
  localparam int NAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic        ev_valid = 1'b0, ev_dealloc = 1'b0;
  logic [11:0] ev_mcid = '0;
  logic [11:0] ev_rcid = '0;
  logic [2:0]  ev_at = '0;
  logic [63:0] ctl_a, snap_a, ctl_p, snap_p;

  always #2.5 clk = ~clk;

  cap_usage_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .ctl_rdata(ctl_a), .snap_rdata(snap_a), .ev_valid(ev_valid),
    .ev_dealloc(ev_dealloc), .ev_mcid(ev_mcid), .ev_rcid(ev_rcid), .ev_at(ev_at));

  cap_usage_monitor #(.PFX_EN(1), .PFX_BITS(2)) dut_p_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .ctl_rdata(ctl_p), .snap_rdata(snap_p), .ev_valid(ev_valid),
    .ev_dealloc(ev_dealloc), .ev_mcid(ev_mcid), .ev_rcid(ev_rcid), .ev_at(ev_at));

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  typedef struct { logic [6:0] st; logic [63:0] snap; string tag; } exp_t;
  exp_t sbq[$];

  int unsigned mctr[NC];
  bit          men[NC], matv[NC];
  int          mat[NC];
  logic [63:0] msnap = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_st(int op, int mcid, int evt, bit atv, int at);
    if (op != 1 && op != 2) return 7'd2;
    if (mcid >= NC) return 7'd3;
    if (op == 1 && evt > 1) return 7'd4;
    if (op == 1 && atv && at >= NAT) return 7'd5;
    return 7'd1;
  endfunction

  function automatic logic [63:0] pack(int op, int mcid, int evt, bit atv, int at);
    return {35'd0, atv, 8'(evt), 12'(mcid), 3'(at), 5'(op)};
  endfunction

  function automatic exp_t model_op(int op, int mcid, int evt, bit atv, int at, string tag);
    exp_t e;
    e.st = exp_st(op, mcid, evt, atv, at);
    if (e.st == 7'd1) begin
      if (op == 1) begin
        if (evt == 1) begin men[mcid] = 1; mctr[mcid] = 0; matv[mcid] = atv; mat[mcid] = at; end
        else men[mcid] = 0;
      end else begin
        msnap = {~men[mcid], 63'(mctr[mcid])};
      end
    end
    e.snap = msnap;
    e.tag = tag;
    return e;
  endfunction

  // Driver: pushes the expected outcome, then issues the write. junk lands in
  // reserved, STATUS and BUSY bit positions and must be ignored (R2, R4).
  task automatic do_op(int op, int mcid, int evt, bit atv, int at, string tag,
                       logic [63:0] junk = '0);
    exp_t e;
    e = model_op(op, mcid, evt, atv, at, tag);
    sbq.push_back(e);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = pack(op, mcid, evt, atv, at) | (junk & ~64'h1FFF_FFFF);
    @(negedge clk);
    reg_wr = 1'b0;
    repeat (3) @(negedge clk);
    check({"R2 readback ", tag}, ctl_a,
          {24'd0, 1'b0, e.st, 3'd0, pack(op, mcid, evt, atv, at)[28:0]});
  endtask

  task automatic ev(bit dealloc, int mcid, int rcid, int at);
    @(negedge clk);
    ev_valid = 1'b1; ev_dealloc = dealloc;
    ev_mcid = 12'(mcid); ev_rcid = 12'(rcid); ev_at = 3'(at);
    if (mcid < NC && men[mcid] && (!matv[mcid] || mat[mcid] == at)) begin
      if (!dealloc) mctr[mcid]++;
      else if (mctr[mcid] != 0) mctr[mcid]--;
    end
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  // Monitor: on each falling BUSY, pop and compare status, snapshot and span.
  initial begin
    bit pb = 0, b;
    int rise = 0;
    forever begin
      @(posedge clk); #1;
      b = ctl_a[39];
      if (!pb && b) begin
        rise = cyc;
        check("R3 status cleared on accept", 64'(ctl_a[38:32]), 64'd0);
      end
      if (pb && !b) begin
        if (sbq.size() == 0) begin
          check("R4 unexpected completion", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check({"R3 busy span ", e.tag}, 64'(cyc - rise), 64'd2);
          check({"R5 status ", e.tag}, 64'(ctl_a[38:32]), 64'(e.st));
          check({"R10 snapshot ", e.tag}, snap_a, e.snap);
        end
      end
      pb = b;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NC; i++) begin men[i] = 0; mctr[i] = 0; matv[i] = 0; mat[i] = 0; end
    repeat (4) @(negedge clk);
    check("R1 ctl reset", ctl_a, 64'd0);
    check("R1 snap reset", snap_a, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    do_op(2, 3, 0, 0, 0, "R10 read unconfigured (inv)");
    do_op(1, 3, 1, 0, 0, "R6 cfg ctr3");
    ev(0, 3, 0, 0); ev(0, 3, 0, 5); ev(0, 3, 0, 2); ev(1, 3, 0, 7);
    do_op(2, 3, 0, 0, 0, "R7 R8 ctr3 all AT");
    repeat (4) ev(1, 3, 0, 1);
    do_op(2, 3, 0, 0, 0, "R9 floor at zero");
    ev(0, 3, 0, 0);
    do_op(2, 3, 0, 0, 0, "R9 counts after floor");

    do_op(1, 5, 1, 1, 2, "R8 cfg ctr5 AT2");
    ev(0, 5, 0, 2); ev(0, 5, 0, 2); ev(0, 5, 0, 1); ev(1, 5, 0, 3);
    ev(0, 20, 0, 2);
    do_op(2, 5, 0, 0, 0, "R8 R11 filtered and dropped");

    do_op(0, 5, 1, 0, 0, "R5 op0 invalid");
    do_op(7, 5, 1, 0, 0, "R5 op7 invalid");
    do_op(2, 16, 0, 0, 0, "R5 mcid out of range");
    do_op(1, 5, 2, 0, 0, "R5 R12 bad event");
    do_op(1, 5, 1, 1, 5, "R5 R12 bad AT");
    do_op(9, 20, 3, 1, 6, "R5 priority op first");
    do_op(1, 20, 3, 1, 6, "R5 priority id second");
    do_op(1, 4, 3, 1, 6, "R5 priority evt third");
    do_op(2, 5, 0, 0, 0, "R12 ctr5 untouched");

    do_op(1, 5, 0, 0, 0, "R6 stop ctr5");
    ev(0, 5, 0, 2);
    do_op(2, 5, 0, 0, 0, "R6 stopped holds value");
    do_op(1, 5, 1, 0, 0, "R6 restart clears", 64'hFFFF_FFFF_E000_0000);
    do_op(2, 5, 0, 0, 0, "R6 R2 cleared, junk ignored", 64'hFFFF_FF00_0000_0000);

    // R4: a second write during BUSY is dropped.
    begin
      exp_t e;
      e = model_op(2, 3, 0, 0, 0, "R4 first write wins");
      sbq.push_back(e);
      @(negedge clk); reg_wr = 1'b1; reg_wdata = pack(2, 3, 0, 0, 0);
      @(negedge clk); reg_wdata = pack(1, 5, 0, 0, 0);
      @(negedge clk); reg_wr = 1'b0;
      repeat (3) @(negedge clk);
      check("R4 fields from first write", 64'(ctl_a[28:0]), 64'(pack(2, 3, 0, 0, 0)));
      ev(0, 5, 0, 0);
      do_op(2, 5, 0, 0, 0, "R4 ctr5 still counting");
    end

    // R11: prefixed instance shares stimulus; index = (rcid << 2) | mcid[1:0].
    do_op(1, 6, 1, 0, 0, "R11 cfg ctr6");
    ev(0, 2, 1, 0);
    ev(0, 2, 5, 0);
    ev(0, 14, 1, 0);
    do_op(2, 6, 0, 0, 0, "R11 direct ctr6");
    check("R11 prefixed index hit", snap_p, {1'b0, 63'd2});

    while (sbq.size() != 0) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule